// File: doc/BRIEF.md
# General-Purpose I/O Bank

This block is the digital core of a bank of 32 general-purpose pins, driven through a register port. The output data latch and the direction register each have two write-only views. One view sets bits and the other clears bits, so software can change a single pin without reading the register first. A plain read/write register turns the pull resistor off for each pin. While a pin is an input, its output data bit picks between pull-up and pull-down.

The block drives four per-pin signals toward the pad ring: output enable, output value, pull enable and pull polarity. The pad levels pass through a synchronizer and can then be read as a data word. Two write channels share the register file, so two masters can each reach it in the same cycle. Reads are combinational on a separate read address.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin is an input (`padOe` all 0), every output data bit is 0 (`padOut` and `pullUp` all 0), and every pull is enabled (`pullEn` all 1).
- R2: A write to address 1 sets every output data bit that is 1 in the written word, one clock later. Bits that are 0 in the word keep their value.
- R3: A write to address 2 clears every output data bit that is 1 in the written word, one clock later. Other bits keep their value.
- R4: A write to address 3 turns the marked pins into outputs. A write to address 4 turns the marked pins into inputs. `padOe` shows the direction bits (1 = output), and reading address 3 or 4 returns them.
- R5: Address 5 holds the pull-off word, which is written whole and read back whole. `pullEn` for a pin is 1 only when its pull-off bit is 0 and the pin is an input.
- R6: `pullUp` carries the output data bit of each pin: for an input pin with its pull on, 1 selects pull-up and 0 selects pull-down. Reading address 1 or 2 returns the output data latch.
- R7: Reading address 0 returns the pad levels two clock edges after they were applied. A change is not visible after only one edge.
- R8: When both channels write in one cycle, their set and clear masks merge and a clear beats a set on the same bit. When both channels write address 5, channel 1's word is taken.
- R9: Writes to addresses 0, 6 and 7 change nothing. Reading address 6 or 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 2 | Write strobe per channel |
| wrAddr | input | 6 | Write address per channel, 3 bits each, channel 0 in the low bits |
| wrData | input | 64 | Write data per channel, 32 bits each, channel 0 in the low bits |
| rdAddr | input | 3 | Read address |
| rdData | output | 32 | Read data for `rdAddr` |
| padIn | input | 32 | Pad input levels |
| padOe | output | 32 | Per-pin output enable |
| padOut | output | 32 | Per-pin output value |
| pullEn | output | 32 | Per-pin pull resistor enable |
| pullUp | output | 32 | Per-pin pull polarity, 1 = up |

## Verification
The set and clear properties assume that the other channel is idle, or that it does not touch the same register view, when they check one channel alone. The stimulus table drives both channels at once only in the rows meant to test merging. The level-read property takes the pad inputs as clean, clock-synchronous values. The bench therefore changes `padIn` only on the falling edge, so the two-edge delay can be counted exactly.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BANK_PINS = 32;
  localparam int ADDR_W    = 3;

  localparam logic [ADDR_W-1:0] ADDR_LEVEL    = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_DOUT_SET = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_DOUT_CLR = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_DIR_SET  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_DIR_CLR  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_PULL_OFF = 3'd5;

  typedef struct packed {
    logic [BANK_PINS-1:0] doutSet;
    logic [BANK_PINS-1:0] doutClr;
    logic [BANK_PINS-1:0] dirSet;
    logic [BANK_PINS-1:0] dirClr;
    logic                 pullWr;
    logic [BANK_PINS-1:0] pullData;
  } strobe_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int WR_PORTS = 2
) (
  input  logic [WR_PORTS-1:0]           wrEn,
  input  logic [WR_PORTS*ADDR_W-1:0]    wrAddr,
  input  logic [WR_PORTS*BANK_PINS-1:0] wrData,
  output strobe_t                       strobe
);
  always_comb begin
    strobe = '0;
    // Ascending loop: a later channel overrides an earlier one on the plain register.
    for (int p = 0; p < WR_PORTS; p++) begin
      if (wrEn[p]) begin
        unique case (wrAddr[p*ADDR_W +: ADDR_W])
          ADDR_DOUT_SET: strobe.doutSet = strobe.doutSet | wrData[p*BANK_PINS +: BANK_PINS];
          ADDR_DOUT_CLR: strobe.doutClr = strobe.doutClr | wrData[p*BANK_PINS +: BANK_PINS];
          ADDR_DIR_SET:  strobe.dirSet  = strobe.dirSet  | wrData[p*BANK_PINS +: BANK_PINS];
          ADDR_DIR_CLR:  strobe.dirClr  = strobe.dirClr  | wrData[p*BANK_PINS +: BANK_PINS];
          ADDR_PULL_OFF: begin
            strobe.pullWr   = 1'b1;
            strobe.pullData = wrData[p*BANK_PINS +: BANK_PINS];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [BANK_PINS-1:0] rdData,
  input  logic [BANK_PINS-1:0] padIn,
  output logic [BANK_PINS-1:0] padOe,
  output logic [BANK_PINS-1:0] padOut,
  output logic [BANK_PINS-1:0] pullEn,
  output logic [BANK_PINS-1:0] pullUp
);
  logic [BANK_PINS-1:0] doutQ;
  logic [BANK_PINS-1:0] dirQ;
  logic [BANK_PINS-1:0] pullOffQ;
  logic [BANK_PINS-1:0] syncQ [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doutQ    <= '0;
      dirQ     <= '0;
      pullOffQ <= '0;
    end else begin
      // Clear is applied after set, so it wins on a shared bit.
      doutQ <= (doutQ | strobe.doutSet) & ~strobe.doutClr;
      dirQ  <= (dirQ  | strobe.dirSet)  & ~strobe.dirClr;
      if (strobe.pullWr) pullOffQ <= strobe.pullData;
    end
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= padIn;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_comb begin
    unique case (rdAddr)
      ADDR_LEVEL:                   rdData = syncQ[SYNC_STAGES-1];
      ADDR_DOUT_SET, ADDR_DOUT_CLR: rdData = doutQ;
      ADDR_DIR_SET, ADDR_DIR_CLR:   rdData = dirQ;
      ADDR_PULL_OFF:                rdData = pullOffQ;
      default:                      rdData = '0;
    endcase
  end

  assign padOe  = dirQ;
  assign padOut = doutQ;
  assign pullEn = ~pullOffQ & ~dirQ;
  assign pullUp = doutQ;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int WR_PORTS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [WR_PORTS-1:0]           wrEn,
  input  logic [WR_PORTS*ADDR_W-1:0]    wrAddr,
  input  logic [WR_PORTS*BANK_PINS-1:0] wrData,
  input  logic [ADDR_W-1:0]             rdAddr,
  output logic [BANK_PINS-1:0]          rdData,
  input  logic [BANK_PINS-1:0]          padIn,
  output logic [BANK_PINS-1:0]          padOe,
  output logic [BANK_PINS-1:0]          padOut,
  output logic [BANK_PINS-1:0]          pullEn,
  output logic [BANK_PINS-1:0]          pullUp
);
  strobe_t strobe;

  gpio_bank_ctrl #(.WR_PORTS(WR_PORTS)) u_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .strobe (strobe)
  );

  gpio_bank_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .padIn  (padIn),
    .padOe  (padOe),
    .padOut (padOut),
    .pullEn (pullEn),
    .pullUp (pullUp)
  );
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker
  import gpio_bank_pkg::*;
#(
  parameter int WR_PORTS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [WR_PORTS-1:0]           wrEn,
  input logic [WR_PORTS*ADDR_W-1:0]    wrAddr,
  input logic [WR_PORTS*BANK_PINS-1:0] wrData,
  input logic [ADDR_W-1:0]             rdAddr,
  input logic [BANK_PINS-1:0]          rdData,
  input logic [BANK_PINS-1:0]          padIn,
  input logic [BANK_PINS-1:0]          padOe,
  input logic [BANK_PINS-1:0]          padOut,
  input logic [BANK_PINS-1:0]          pullEn
);
  logic [1:0] sinceRst;
  logic       otherIdle;
  logic       anyRegWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assign otherIdle = (WR_PORTS == 1) ? 1'b1 : (wrEn[WR_PORTS-1:1] == '0);

  always_comb begin
    anyRegWr = 1'b0;
    for (int p = 0; p < WR_PORTS; p++) begin
      if (wrEn[p] && wrAddr[p*ADDR_W +: ADDR_W] >= ADDR_DOUT_SET
          && wrAddr[p*ADDR_W +: ADDR_W] <= ADDR_PULL_OFF)
        anyRegWr = 1'b1;
    end
  end

  assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn[0] && otherIdle && wrAddr[ADDR_W-1:0] == ADDR_DOUT_SET)
      |=> ((padOut & $past(wrData[BANK_PINS-1:0])) == $past(wrData[BANK_PINS-1:0])));

  assert_clear_bits_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn[0] && wrAddr[ADDR_W-1:0] == ADDR_DOUT_CLR)
      |=> ((padOut & $past(wrData[BANK_PINS-1:0])) == '0));

  assert_dir_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn[0] && otherIdle && wrAddr[ADDR_W-1:0] == ADDR_DIR_SET)
      |=> ((padOe & $past(wrData[BANK_PINS-1:0])) == $past(wrData[BANK_PINS-1:0])));

  assert_no_pull_on_output_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((pullEn & padOe) == '0));

  assert_ignored_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!anyRegWr) |=> ($stable(padOut) && $stable(padOe) && $stable(pullEn)));

  generate
    if (SYNC_STAGES == 2) begin : g_lvl
      assert_level_delay_R7: assert property (@(posedge clk) disable iff (!rstN)
        (sinceRst >= 2'd2 && rdAddr == ADDR_LEVEL) |-> (rdData == $past(padIn, 2)));
    end
  endgenerate
endmodule

bind gpio_bank gpio_bank_checker #(.WR_PORTS(WR_PORTS), .SYNC_STAGES(SYNC_STAGES)) u_checker (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrAddr (wrAddr),
  .wrData (wrData),
  .rdAddr (rdAddr),
  .rdData (rdData),
  .padIn  (padIn),
  .padOe  (padOe),
  .padOut (padOut),
  .pullEn (pullEn)
);

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  wrEn = '0;
  logic [5:0]  wrAddr = '0;
  logic [63:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [31:0] padIn = '0;
  logic [31:0] padOe, padOut, pullEn, pullUp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_bank u_gpio_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .padIn(padIn), .padOe(padOe),
    .padOut(padOut), .pullEn(pullEn), .pullUp(pullUp)
  );

  typedef struct packed {
    logic        e0;
    logic [2:0]  a0;
    logic [31:0] d0;
    logic        e1;
    logic [2:0]  a1;
    logic [31:0] d1;
    logic [31:0] xOut;
    logic [31:0] xOe;
    logic [31:0] xPe;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 3'd1, 32'h0000_00F0, 1'b0, 3'd0, 32'h0, 32'h0000_00F0, 32'h0000_0000, 32'hFFFF_FFFF}, // R2
    '{1'b1, 3'd1, 32'h0F00_0000, 1'b0, 3'd0, 32'h0, 32'h0F00_00F0, 32'h0000_0000, 32'hFFFF_FFFF}, // R2
    '{1'b1, 3'd2, 32'h0000_0030, 1'b0, 3'd0, 32'h0, 32'h0F00_00C0, 32'h0000_0000, 32'hFFFF_FFFF}, // R3
    '{1'b1, 3'd3, 32'h0000_FF00, 1'b0, 3'd0, 32'h0, 32'h0F00_00C0, 32'h0000_FF00, 32'hFFFF_00FF}, // R4
    '{1'b1, 3'd4, 32'h0000_0F00, 1'b0, 3'd0, 32'h0, 32'h0F00_00C0, 32'h0000_F000, 32'hFFFF_0FFF}, // R4
    '{1'b1, 3'd5, 32'h0000_00FF, 1'b0, 3'd0, 32'h0, 32'h0F00_00C0, 32'h0000_F000, 32'hFFFF_0F00}, // R5
    '{1'b1, 3'd1, 32'h0000_0101, 1'b1, 3'd2, 32'h0000_0100, 32'h0F00_00C1, 32'h0000_F000, 32'hFFFF_0F00}, // R8
    '{1'b1, 3'd5, 32'h0000_000F, 1'b1, 3'd5, 32'h0000_00F0, 32'h0F00_00C1, 32'h0000_F000, 32'hFFFF_0F0F}, // R8
    '{1'b1, 3'd6, 32'hFFFF_FFFF, 1'b1, 3'd0, 32'hFFFF_FFFF, 32'h0F00_00C1, 32'h0000_F000, 32'hFFFF_0F0F}, // R9
    '{1'b1, 3'd3, 32'h0000_00FF, 1'b1, 3'd4, 32'h0000_0003, 32'h0F00_00C1, 32'h0000_F0FC, 32'hFFFF_0F03}  // R8
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic readCheck(input logic [2:0] a, input string req, input logic [31:0] exp);
    rdAddr = a;
    #0.5;
    check(req, rdData, exp);
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 padOe", padOe, 32'h0);
    check("R1 padOut", padOut, 32'h0);
    check("R1 pullEn", pullEn, 32'hFFFF_FFFF);
    check("R1 pullUp", pullUp, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", padOut | padOe, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      wrEn   = {VECS[i].e1, VECS[i].e0};
      wrAddr = {VECS[i].a1, VECS[i].a0};
      wrData = {VECS[i].d1, VECS[i].d0};
      @(posedge clk);
      @(negedge clk);
      wrEn = '0;
      check($sformatf("R2/R3/R8/R9 padOut vec %0d", i), padOut, VECS[i].xOut);
      check($sformatf("R4/R8 padOe vec %0d", i), padOe, VECS[i].xOe);
      check($sformatf("R5/R8 pullEn vec %0d", i), pullEn, VECS[i].xPe);
      check($sformatf("R6 pullUp vec %0d", i), pullUp, VECS[i].xOut);
    end

    // Readback of each register view
    readCheck(3'd1, "R6 read dout set view", 32'h0F00_00C1);
    readCheck(3'd2, "R6 read dout clr view", 32'h0F00_00C1);
    readCheck(3'd3, "R4 read dir", 32'h0000_F0FC);
    readCheck(3'd4, "R4 read dir clr view", 32'h0000_F0FC);
    readCheck(3'd5, "R5 read pull-off", 32'h0000_00F0);
    readCheck(3'd6, "R9 read addr 6", 32'h0);
    readCheck(3'd7, "R9 read addr 7", 32'h0);

    // R7 two-edge synchronizer
    @(negedge clk);
    rdAddr = 3'd0;
    padIn  = 32'hA5A5_5A5A;
    @(negedge clk);
    check("R7 not after one edge", rdData, 32'h0);
    @(negedge clk);
    check("R7 after two edges", rdData, 32'hA5A5_5A5A);
    padIn = 32'h0000_FFFF;
    @(negedge clk);
    @(negedge clk);
    check("R7 second pattern", rdData, 32'h0000_FFFF);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule